// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Generator

This block turns a single request into the timed strobe sequence of an external bus. On that bus the low address byte and the data byte share one 8-bit port. An address latch enable pulse separates the two phases. The high address byte has its own dedicated outputs. One clock period of the block equals one oscillator period, and every strobe edge falls on a whole number of periods from the start of the cycle.

The block runs two kinds of cycle. A program fetch lowers a program-store strobe for three periods and captures the instruction byte just before that strobe rises. A data cycle lowers a read or a write strobe for six periods. On a read, the port driver is released and the returned byte is captured late in the strobe. On a write, the data byte is driven around the strobe. A done flag is high during the last period of each cycle. A request presented in that period, or while the block is idle, starts the next cycle in the following period. This keeps the next address latch pulse one period after the previous strobe rises.

Period numbers below count from 0, the first period of a cycle, in which the address latch enable is high.

Top module: `extbus_cycle_gen`

## Requirements
- R1: `ale` is high in periods 0 and 1 of every cycle and low in all other periods.
- R2: On `req` acceptance, the block latches `addr`, `cyc_data`, `cyc_write` and `wdata`. `ad_out` carries `addr[7:0]` with `ad_oe` high in periods 0 to 2. `addr_hi` carries `addr[15:8]` throughout the cycle.
- R3: A fetch cycle (`cyc_data`=0) drives `psen_n` low in periods 3 to 5 only, and keeps `rd_n` and `wr_n` high. `cyc_write` is ignored in a fetch cycle.
- R4: A fetch cycle samples `ad_in` at the clock edge that ends period 5 and presents the sampled byte on `rdata` from period 6 on.
- R5: A data cycle (`cyc_data`=1) drives `rd_n` low in periods 5 to 10 when `cyc_write`=0, or `wr_n` low in periods 5 to 10 when `cyc_write`=1. `psen_n` stays high.
- R6: A write cycle holds `ad_oe` low in period 3. It drives `wdata` on `ad_out` with `ad_oe` high in periods 4 to 11.
- R7: A read cycle holds `ad_oe` low from period 3 to the end of the cycle. It samples `ad_in` at the edge that ends period 9. A write cycle leaves `rdata` unchanged.
- R8: `done` is high only in the last period: period 6 for a fetch and period 11 for a data cycle. A request seen in that period starts a new cycle, with `ale` high, in the very next period.
- R9: `req` and the cycle inputs are ignored in every period of a cycle except the last one.
- R10: After reset, and whenever the block is idle: `ale`=0, `ad_oe`=0, `done`=0, and all three strobes are high. Reset clears `rdata` to 0.
- R11: At most one of `psen_n`, `rd_n`, `wr_n` is low at a time, and none of them is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one period per bus time unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Cycle request |
| cyc_data | input | 1 | 1 selects a data cycle, 0 a program fetch |
| cyc_write | input | 1 | In a data cycle, 1 selects write, 0 read |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Write data byte |
| ad_in | input | 8 | Byte read from the shared port |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Byte driven onto the shared port |
| ad_oe | output | 1 | Output enable for the shared port |
| addr_hi | output | 8 | High address byte |
| rdata | output | 8 | Last captured fetch or read byte |
| done | output | 1 | High in the final period of a cycle |

## Verification
On every cycle, the assertions check the relative placement of the edges. They check that `ale` is exactly two periods wide, that each strobe falls the set number of periods after `ale`, and that the port is released under a read strobe and driven under a write strobe. They also check the single-period `done`, strobe exclusivity and the idle state. Some behaviours appear only in the bench's scenarios, because they depend on values rather than edges. These are the capture instants of `rdata`, the byte carried on `ad_out` in each phase, inputs that change mid-cycle, and back-to-back cycles that start in the period after `done`.

// File: rtl/extbus_cycle_gen.sv
module extbus_cycle_gen #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          cyc_data,
  input  logic          cyc_write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] rdata,
  output logic          done
);
  localparam int CW      = 4;
  localparam int T_ALE   = 2;
  localparam int T_ADR   = 2;
  localparam int T_PSLO  = 3;
  localparam int T_PSHI  = 5;
  localparam int T_FCAP  = T_PSHI;
  localparam int T_FLAST = T_PSHI + 1;
  localparam int T_WDAT  = 4;
  localparam int T_DSLO  = 5;
  localparam int T_DSHI  = 10;
  localparam int T_RCAP  = T_DSLO + 4;
  localparam int T_DLAST = T_DSHI + 1;

  logic          busy;
  logic [CW-1:0] cnt;
  logic          op_data, op_wr;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic          last, start, in_ps, in_ds, fcap, rcap;

  assign last  = busy && (cnt == CW'(op_data ? T_DLAST : T_FLAST));
  assign start = req && (!busy || last);
  assign in_ps = busy && !op_data && cnt >= CW'(T_PSLO) && cnt <= CW'(T_PSHI);
  assign in_ds = busy && op_data && cnt >= CW'(T_DSLO) && cnt <= CW'(T_DSHI);
  assign fcap  = busy && !op_data && cnt == CW'(T_FCAP);
  assign rcap  = busy && op_data && !op_wr && cnt == CW'(T_RCAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      op_data <= 1'b0;
      op_wr   <= 1'b0;
      a_q     <= '0;
      wd_q    <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      cnt     <= '0;
      op_data <= cyc_data;
      op_wr   <= cyc_data & cyc_write;
      a_q     <= addr;
      wd_q    <= wdata;
    end else if (last) begin
      busy    <= 1'b0;
    end else if (busy) begin
      cnt     <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rdata <= '0;
    else if (fcap || rcap) rdata <= ad_in;
  end

  assign ale     = busy && cnt < CW'(T_ALE);
  assign psen_n  = !in_ps;
  assign rd_n    = !(in_ds && !op_wr);
  assign wr_n    = !(in_ds && op_wr);
  assign ad_oe   = busy && (cnt <= CW'(T_ADR) || (op_wr && cnt >= CW'(T_WDAT)));
  assign ad_out  = (cnt <= CW'(T_ADR)) ? a_q[DW-1:0] : wd_q;
  assign addr_hi = a_q[AW-1:DW];
  assign done    = last;
endmodule

module extbus_cycle_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic done
);
  p_ale_two_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);
  p_ale_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale)) |=> !ale);
  p_psen_place_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> (!$past(ale) && $past(ale, 2)));
  p_rd_place_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (!$past(ale, 3) && $past(ale, 4)));
  p_wr_place_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> (!$past(ale, 3) && $past(ale, 4)));
  p_wr_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || $rose(wr_n)) |-> ad_oe);
  p_rd_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ale && !ad_oe && !done && psen_n && rd_n && wr_n));
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n, ale}) <= 1);
endmodule

bind extbus_cycle_gen extbus_cycle_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .done(done)
);

// File: tb/sim_extbus_cycle_gen.sv
module sim_extbus_cycle_gen;
  logic clk = 0, rst_n = 0, req = 0, cyc_data = 0, cyc_write = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0, ad_in = 0;
  logic ale, psen_n, rd_n, wr_n, ad_oe, done;
  logic [7:0] ad_out, addr_hi, rdata;
  int total = 0, bad = 0;
  logic [7:0] exp_rd = 0;
  int n_op; logic [15:0] n_a; logic [7:0] n_w, n_r;

  always #10 clk = ~clk;

  extbus_cycle_gen u0 (.clk(clk), .rst_n(rst_n), .req(req), .cyc_data(cyc_data),
    .cyc_write(cyc_write), .addr(addr), .wdata(wdata), .ad_in(ad_in), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .rdata(rdata), .done(done));

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int last_of(int op); return (op == 0) ? 6 : 11; endfunction
  function automatic int cap_of(int op);  return (op == 0) ? 5 : 9;  endfunction

  task automatic apply(int op, logic [15:0] a, logic [7:0] w);
    cyc_data  = (op != 0);
    cyc_write = (op == 2) ? 1'b1 : ((op == 0) ? 1'($urandom % 2) : 1'b0);
    addr = a; wdata = w; req = 1'b1;
  endtask

  task automatic idle_chk(string tag);
    @(negedge clk);
    chk(tag, {ale, ad_oe, done, psen_n, rd_n, wr_n}, 6'b000111);
  endtask

  task automatic run_cycle(int op, logic [15:0] a, logic [7:0] w, logic [7:0] r,
                           bit chain, bit hold);
    int last = last_of(op);
    int cap = cap_of(op);
    for (int t = 0; t <= last; t++) begin
      @(negedge clk);
      if (t == 0 && !hold) req = 1'b0;
      if (hold && t == 1) apply(2, ~a, ~w);
      if (hold && t == last - 1) req = 1'b0;
      ad_in = (t == cap) ? r : ~r;
      chk("R1", ale, t < 2);
      chk("R3", psen_n, !(op == 0 && t >= 3 && t <= 5));
      chk("R5", {rd_n, wr_n}, {!(op == 1 && t >= 5 && t <= 10), !(op == 2 && t >= 5 && t <= 10)});
      chk("R8", done, t == last);
      chk("R2", addr_hi, a[15:8]);
      if (t <= 2) begin
        chk("R2", {ad_oe, ad_out}, {1'b1, a[7:0]});
      end else if (op == 2) begin
        if (t == 3) chk("R6", ad_oe, 1'b0);
        else chk("R6", {ad_oe, ad_out}, {1'b1, w});
      end else begin
        chk("R7", ad_oe, 1'b0);
      end
      if (t == last) begin
        if (op != 2) exp_rd = r;
        chk(op == 0 ? "R4" : "R7", rdata, exp_rd);
        if (chain) apply(n_op, n_a, n_w);
      end
    end
  endtask

  task automatic gen_next();
    n_op = $urandom % 3; n_a = 16'($urandom); n_w = 8'($urandom); n_r = 8'($urandom);
  endtask

  initial begin
    int c_op; logic [15:0] c_a; logic [7:0] c_w, c_r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10", {ale, ad_oe, done, psen_n, rd_n, wr_n, rdata}, {6'b000111, 8'h00});
    rst_n = 1'b1;
    idle_chk("R10");
    idle_chk("R10");

    // directed: fetch, read, write with edge-case data
    c_op = 0; c_a = 16'hFF00; c_w = 8'h00; c_r = 8'hA5;
    @(negedge clk); apply(c_op, c_a, c_w);
    n_op = 1; n_a = 16'h00FF; n_w = 8'h00; n_r = 8'h5A;
    run_cycle(c_op, c_a, c_w, c_r, 1'b1, 1'b0);
    c_op = n_op; c_a = n_a; c_w = n_w; c_r = n_r;
    n_op = 2; n_a = 16'h8001; n_w = 8'hFF; n_r = 8'h00;
    run_cycle(c_op, c_a, c_w, c_r, 1'b1, 1'b0);
    run_cycle(n_op, n_a, n_w, n_r, 1'b0, 1'b0);
    idle_chk("R10");

    // random mix of chained and spaced cycles
    gen_next();
    c_op = n_op; c_a = n_a; c_w = n_w; c_r = n_r;
    @(negedge clk); apply(c_op, c_a, c_w);
    for (int i = 0; i < 300; i++) begin
      bit chain;
      gen_next();
      chain = (i != 299) && ($urandom % 2 == 1);
      run_cycle(c_op, c_a, c_w, c_r, chain, 1'b0);
      if (!chain) begin
        int gap = 1 + $urandom % 3;
        for (int g = 0; g < gap; g++) idle_chk("R10");
        if (i != 299) apply(n_op, n_a, n_w);
      end
      c_op = n_op; c_a = n_a; c_w = n_w; c_r = n_r;
    end

    // R9: request and inputs changed mid-cycle, dropped before done
    @(negedge clk); apply(0, 16'h3C4D, 8'h11);
    run_cycle(0, 16'h3C4D, 8'h11, 8'h77, 1'b0, 1'b1);
    idle_chk("R9");
    idle_chk("R9");
    @(negedge clk); apply(1, 16'h1234, 8'h22);
    run_cycle(1, 16'h1234, 8'h22, 8'h99, 1'b0, 1'b1);
    idle_chk("R9");
    @(negedge clk); apply(2, 16'hABCD, 8'h33);
    run_cycle(2, 16'hABCD, 8'h33, 8'h44, 1'b0, 1'b1);
    idle_chk("R9");
    chk("R7", rdata, exp_rd);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule